// File: doc/BRIEF.md
# AXI to Wishbone burst bridge

This block is the slave end of an AXI4 port that reaches a single-master Wishbone classic bus. It accepts whole write and read bursts with 32-bit data, 32-bit byte addresses and 8-bit transaction IDs. It breaks each burst into its individual beats. Every beat runs as one Wishbone cycle on a 32-bit bus that is addressed by word.

A write burst takes its data beats from the write-data channel, one beat at a time. Each beat goes out with the next beat address and with the beat's byte strobes. When the last beat has been acknowledged, the bridge returns one response carrying the burst's ID. A read burst fetches one word per Wishbone cycle and hands it back on the read-data channel with the burst's ID. The last flag is set on the final beat only.

The bridge owns the bus for a whole burst. When a read and a write are both waiting, a small arbiter picks one of them, and the preference alternates between the two directions. The response code is always OKAY.

Top module: `axi_wb_bridge`

## Requirements
- R1: Out of reset, aw_ready and ar_ready are 1, and b_valid, r_valid and wb_cyc are 0.
- R2: A burst whose length field is L makes exactly L+1 Wishbone cycles, one per beat. Each cycle presents the beat's byte address shifted right by 2 on wb_adr.
- R3: Burst type 2'b01 (incrementing) adds 2^size bytes to the address from one beat to the next.
- R4: Burst type 2'b00 (fixed) uses the starting address for every beat.
- R5: Burst type 2'b10 (wrapping) adds 2^size per beat and wraps inside the aligned window of (L+1)*2^size bytes that holds the start address. A start address that is not aligned to the window therefore wraps back to the window base.
- R6: On a write beat, wb_sel equals that beat's w_strb (bit n selects data byte n). Read cycles drive wb_sel to 4'b1111.
- R7: Each write burst returns exactly one write response. The response carries the burst's ID and b_resp = 2'b00. It is raised only after the Wishbone acknowledge of the beat flagged w_last.
- R8: Each read beat returns the word acknowledged on the bus, the read burst's ID and r_resp = 2'b00. r_last is 1 on the final beat only.
- R9: b_valid and r_valid, together with their payloads, stay unchanged until the master's ready. wb_cyc and wb_stb, with address, select and data, stay unchanged until wb_ack. Gaps in aw_valid, w_valid and ar_valid are tolerated.
- R10: Once a burst has started on the bus, it runs to completion before any beat of the other direction. When a write and a read are both pending at the same decision, the winner is the direction that was not served last. The first decision after reset favours the write.
- R11: At most one Wishbone cycle is active at a time. The bus is idle while a write response or a read beat waits for the master.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write burst command valid |
| aw_ready | output | 1 | Write burst command accepted |
| aw_addr | input | 32 | Write burst start byte address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | log2 of bytes per write beat |
| aw_burst | input | 2 | Write burst type (00 fixed, 01 incr, 10 wrap) |
| aw_id | input | 8 | Write burst ID |
| w_valid | input | 1 | Write data beat valid |
| w_ready | output | 1 | Write data beat accepted |
| w_data | input | 32 | Write data |
| w_strb | input | 4 | Write byte strobes |
| w_last | input | 1 | Final write beat of the burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | 8 | ID of the completed write burst |
| b_resp | output | 2 | Write response code, always 00 |
| ar_valid | input | 1 | Read burst command valid |
| ar_ready | output | 1 | Read burst command accepted |
| ar_addr | input | 32 | Read burst start byte address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | log2 of bytes per read beat |
| ar_burst | input | 2 | Read burst type (00 fixed, 01 incr, 10 wrap) |
| ar_id | input | 8 | Read burst ID |
| r_valid | output | 1 | Read data beat valid |
| r_ready | input | 1 | Read data beat taken |
| r_data | output | 32 | Read data |
| r_id | output | 8 | ID of the read burst |
| r_resp | output | 2 | Read response code, always 00 |
| r_last | output | 1 | Final read beat of the burst |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 30 | Wishbone word address |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_dat_w | output | 32 | Wishbone write data |
| wb_dat_r | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The bench's slave answers every Wishbone cycle after a random wait of zero to two cycles. It records the address, direction and byte selects of each cycle, so the beat sequence of every burst can be compared with addresses computed independently for fixed, incrementing and wrapping bursts. A wrapping burst that starts in the middle of its window tells a true wrap apart from a plain increment. Single-beat, 256-beat and sub-word-size bursts exercise the beat counter and the repeated word addresses. Random stalls on every channel, with random strobes, show whether payloads are held and whether byte lanes are merged correctly; reads of the written region confirm the merge. A write and a read issued in the same cycle, once after a lone write and once after a lone read, show whether bursts stay unbroken and whether the preference alternates.

// File: rtl/axwb_pkg.sv
package axwb_pkg;

    localparam int AXI_AW     = 32;
    localparam int AXI_DW     = 32;
    localparam int AXI_IDW    = 8;
    localparam int AXI_LENW   = 8;
    localparam int AXI_SZW    = 3;
    localparam int STRB_W     = AXI_DW / 8;
    localparam int WORD_SHIFT = $clog2(STRB_W);
    localparam int WB_AW      = AXI_AW - WORD_SHIFT;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10
    } burst_e;

    localparam logic [1:0] RESP_OK = 2'b00;

    typedef struct packed {
        logic [AXI_AW-1:0]   addr;
        logic [AXI_LENW-1:0] len;
        logic [AXI_SZW-1:0]  size;
        burst_e              kind;
        logic [AXI_IDW-1:0]  id;
    } burst_cmd_t;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_WDATA,
        EN_WBUS,
        EN_BRESP,
        EN_RISSUE,
        EN_RBUS,
        EN_RRESP
    } eng_state_e;

    // Address of the beat after cur, following the burst type rules.
    function automatic logic [AXI_AW-1:0] next_beat_addr(
        input logic [AXI_AW-1:0]   cur,
        input logic [AXI_LENW-1:0] len,
        input logic [AXI_SZW-1:0]  size,
        input burst_e              kind
    );
        logic [AXI_AW-1:0] step;
        logic [AXI_AW-1:0] span;
        logic [AXI_AW-1:0] mask;
        step = AXI_AW'(1) << size;
        span = (AXI_AW'(len) + AXI_AW'(1)) << size;
        mask = span - AXI_AW'(1);
        case (kind)
            BT_FIXED: next_beat_addr = cur;
            BT_WRAP:  next_beat_addr = (cur & ~mask) | ((cur + step) & mask);
            default:  next_beat_addr = cur + step;
        endcase
    endfunction

    function automatic logic [WB_AW-1:0] to_word(input logic [AXI_AW-1:0] byte_addr);
        to_word = byte_addr[AXI_AW-1:WORD_SHIFT];
    endfunction

endpackage

// File: rtl/axwb_burst_track.sv
module axwb_burst_track
    import axwb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  burst_cmd_t           cmd_in,
    input  logic                 advance,
    input  logic                 done,
    output logic                 busy,
    output logic [AXI_AW-1:0]    cur_addr,
    output logic                 last,
    output logic [AXI_IDW-1:0]   id
);

    burst_cmd_t          cmd_q;
    logic [AXI_LENW-1:0] cnt_q;
    logic                busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            cmd_q  <= cmd_in;
        end else begin
            if (advance) begin
                cmd_q.addr <= next_beat_addr(cmd_q.addr, cmd_q.len, cmd_q.size, cmd_q.kind);
                cnt_q      <= cnt_q + AXI_LENW'(1);
            end
            if (done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy     = busy_q;
    assign cur_addr = cmd_q.addr;
    assign last     = (cnt_q == cmd_q.len);
    assign id       = cmd_q.id;

    // R2
    beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> (busy_q && !last));

    // R10
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy_q);

endmodule

// File: rtl/axwb_arbiter.sv
module axwb_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic wr_pend,
    input  logic rd_pend,
    input  logic take,
    output logic pick_wr,
    output logic pick_rd
);

    logic prefer_rd_q;

    assign pick_wr = wr_pend && (!rd_pend || !prefer_rd_q);
    assign pick_rd = rd_pend && !pick_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prefer_rd_q <= 1'b0;
        end else if (take) begin
            prefer_rd_q <= pick_wr;
        end
    end

    // R10
    alt_pref_chk: assert property (@(posedge clk) disable iff (rst)
        (take && wr_pend && rd_pend) |=> (prefer_rd_q == $past(pick_wr)));

endmodule

// File: rtl/axwb_wb_port.sv
module axwb_wb_port
    import axwb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_we,
    input  logic [WB_AW-1:0]   start_adr,
    input  logic [STRB_W-1:0]  start_sel,
    input  logic [AXI_DW-1:0]  start_dat,
    output logic               done,
    output logic [AXI_DW-1:0]  rd_data,
    output logic               wb_cyc,
    output logic               wb_stb,
    output logic               wb_we,
    output logic [WB_AW-1:0]   wb_adr,
    output logic [STRB_W-1:0]  wb_sel,
    output logic [AXI_DW-1:0]  wb_dat_w,
    input  logic [AXI_DW-1:0]  wb_dat_r,
    input  logic               wb_ack
);

    logic              cyc_q;
    logic              we_q;
    logic [WB_AW-1:0]  adr_q;
    logic [STRB_W-1:0] sel_q;
    logic [AXI_DW-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= 1'b0;
            we_q  <= 1'b0;
            adr_q <= '0;
            sel_q <= '0;
            dat_q <= '0;
        end else if (start) begin
            cyc_q <= 1'b1;
            we_q  <= start_we;
            adr_q <= start_adr;
            sel_q <= start_sel;
            dat_q <= start_dat;
        end else if (cyc_q && wb_ack) begin
            cyc_q <= 1'b0;
        end
    end

    assign done     = cyc_q && wb_ack;
    assign rd_data  = wb_dat_r;
    assign wb_cyc   = cyc_q;
    assign wb_stb   = cyc_q;
    assign wb_we    = we_q;
    assign wb_adr   = adr_q;
    assign wb_sel   = sel_q;
    assign wb_dat_w = dat_q;

    // R9
    cyc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q && !wb_ack) |=> (cyc_q && $stable(adr_q) && $stable(sel_q) && $stable(we_q) && $stable(dat_q)));

    // R11
    single_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !cyc_q);

endmodule

// File: rtl/axi_wb_bridge.sv
module axi_wb_bridge
    import axwb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         aw_valid,
    output logic         aw_ready,
    input  logic [31:0]  aw_addr,
    input  logic [7:0]   aw_len,
    input  logic [2:0]   aw_size,
    input  logic [1:0]   aw_burst,
    input  logic [7:0]   aw_id,
    input  logic         w_valid,
    output logic         w_ready,
    input  logic [31:0]  w_data,
    input  logic [3:0]   w_strb,
    input  logic         w_last,
    output logic         b_valid,
    input  logic         b_ready,
    output logic [7:0]   b_id,
    output logic [1:0]   b_resp,
    input  logic         ar_valid,
    output logic         ar_ready,
    input  logic [31:0]  ar_addr,
    input  logic [7:0]   ar_len,
    input  logic [2:0]   ar_size,
    input  logic [1:0]   ar_burst,
    input  logic [7:0]   ar_id,
    output logic         r_valid,
    input  logic         r_ready,
    output logic [31:0]  r_data,
    output logic [7:0]   r_id,
    output logic [1:0]   r_resp,
    output logic         r_last,
    output logic         wb_cyc,
    output logic         wb_stb,
    output logic         wb_we,
    output logic [29:0]  wb_adr,
    output logic [3:0]   wb_sel,
    output logic [31:0]  wb_dat_w,
    input  logic [31:0]  wb_dat_r,
    input  logic         wb_ack
);

    eng_state_e st_q;

    logic              wr_busy, rd_busy;
    logic              wr_last_cnt, rd_last;
    logic [AXI_AW-1:0] wr_addr, rd_addr;
    logic [AXI_IDW-1:0] wr_id, rd_id;
    logic              wr_adv, wr_done, rd_adv, rd_done;
    logic              pick_wr, pick_rd, take;
    logic              bus_start, bus_done;
    logic              bus_we;
    logic [AXI_DW-1:0] bus_rdata;
    logic              wlast_q;
    logic [AXI_DW-1:0] rdata_q;
    burst_cmd_t        aw_cmd, ar_cmd;

    assign aw_cmd = '{addr: aw_addr, len: aw_len, size: aw_size, kind: burst_e'(aw_burst), id: aw_id};
    assign ar_cmd = '{addr: ar_addr, len: ar_len, size: ar_size, kind: burst_e'(ar_burst), id: ar_id};

    assign aw_ready = !wr_busy;
    assign ar_ready = !rd_busy;

    axwb_burst_track u_wtrack (
        .clk      (clk),
        .rst      (rst),
        .load     (aw_valid && aw_ready),
        .cmd_in   (aw_cmd),
        .advance  (wr_adv),
        .done     (wr_done),
        .busy     (wr_busy),
        .cur_addr (wr_addr),
        .last     (wr_last_cnt),
        .id       (wr_id)
    );

    axwb_burst_track u_rtrack (
        .clk      (clk),
        .rst      (rst),
        .load     (ar_valid && ar_ready),
        .cmd_in   (ar_cmd),
        .advance  (rd_adv),
        .done     (rd_done),
        .busy     (rd_busy),
        .cur_addr (rd_addr),
        .last     (rd_last),
        .id       (rd_id)
    );

    assign take = (st_q == EN_IDLE) && (pick_wr || pick_rd);

    axwb_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .wr_pend (wr_busy),
        .rd_pend (rd_busy),
        .take    (take),
        .pick_wr (pick_wr),
        .pick_rd (pick_rd)
    );

    assign bus_we    = (st_q == EN_WDATA);
    assign bus_start = (bus_we && w_valid) || (st_q == EN_RISSUE);

    axwb_wb_port u_port (
        .clk       (clk),
        .rst       (rst),
        .start     (bus_start),
        .start_we  (bus_we),
        .start_adr (bus_we ? to_word(wr_addr) : to_word(rd_addr)),
        .start_sel (bus_we ? w_strb : {STRB_W{1'b1}}),
        .start_dat (w_data),
        .done      (bus_done),
        .rd_data   (bus_rdata),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_we     (wb_we),
        .wb_adr    (wb_adr),
        .wb_sel    (wb_sel),
        .wb_dat_w  (wb_dat_w),
        .wb_dat_r  (wb_dat_r),
        .wb_ack    (wb_ack)
    );

    assign wr_adv  = (st_q == EN_WBUS) && bus_done && !wlast_q;
    assign wr_done = (st_q == EN_BRESP) && b_ready;
    assign rd_adv  = (st_q == EN_RRESP) && r_ready && !rd_last;
    assign rd_done = (st_q == EN_RRESP) && r_ready && rd_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= EN_IDLE;
            wlast_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                EN_IDLE: begin
                    if (pick_wr)      st_q <= EN_WDATA;
                    else if (pick_rd) st_q <= EN_RISSUE;
                end
                EN_WDATA: begin
                    if (w_valid) begin
                        wlast_q <= w_last;
                        st_q    <= EN_WBUS;
                    end
                end
                EN_WBUS: begin
                    if (bus_done) st_q <= wlast_q ? EN_BRESP : EN_WDATA;
                end
                EN_BRESP: begin
                    if (b_ready) st_q <= EN_IDLE;
                end
                EN_RISSUE: st_q <= EN_RBUS;
                EN_RBUS: begin
                    if (bus_done) begin
                        rdata_q <= bus_rdata;
                        st_q    <= EN_RRESP;
                    end
                end
                EN_RRESP: begin
                    if (r_ready) st_q <= rd_last ? EN_IDLE : EN_RISSUE;
                end
                default: st_q <= EN_IDLE;
            endcase
        end
    end

    assign w_ready = (st_q == EN_WDATA);
    assign b_valid = (st_q == EN_BRESP);
    assign b_id    = wr_id;
    assign b_resp  = RESP_OK;
    assign r_valid = (st_q == EN_RRESP);
    assign r_data  = rdata_q;
    assign r_id    = rd_id;
    assign r_resp  = RESP_OK;
    assign r_last  = rd_last;

    // R7
    wlast_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready) |-> (w_last == wr_last_cnt));

    // R7
    b_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(b_valid) |-> $past(wb_ack));

    // R9
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

    // R9
    r_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_last) && $stable(r_id)));

    // R11
    resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (b_valid || r_valid) |-> !wb_cyc);

endmodule

// File: tb/axi_wb_bridge_test.sv
module axi_wb_bridge_test;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_P/2) clk = ~clk;

    logic        aw_valid = 0, w_valid = 0, w_last = 0, b_ready = 0;
    logic        ar_valid = 0, r_ready = 0;
    logic [31:0] aw_addr = 0, ar_addr = 0, w_data = 0;
    logic [7:0]  aw_len = 0, ar_len = 0, aw_id = 0, ar_id = 0;
    logic [2:0]  aw_size = 0, ar_size = 0;
    logic [1:0]  aw_burst = 0, ar_burst = 0;
    logic [3:0]  w_strb = 0;
    logic        aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
    logic [7:0]  b_id, r_id;
    logic [1:0]  b_resp, r_resp;
    logic [31:0] r_data;
    logic        wb_cyc, wb_stb, wb_we;
    logic [29:0] wb_adr;
    logic [3:0]  wb_sel;
    logic [31:0] wb_dat_w;
    logic [31:0] wb_dat_r;
    logic        wb_ack;

    axi_wb_bridge uut (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
        .aw_size(aw_size), .aw_burst(aw_burst), .aw_id(aw_id),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_size(ar_size), .ar_burst(ar_burst), .ar_id(ar_id),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_id(r_id),
        .r_resp(r_resp), .r_last(r_last),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr), .wb_sel(wb_sel),
        .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit fast_issue = 0;

    logic [31:0] slv_mem [0:255];
    logic [31:0] ref_mem [0:255];
    logic [29:0] log_adr [0:2047];
    logic        log_we  [0:2047];
    logic [3:0]  log_sel [0:2047];
    int          log_n = 0;
    int          wait_n = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] beat_addr(input logic [31:0] a, input int i, input int len,
                                              input int size, input logic [1:0] kind);
        logic [31:0] step, span, base;
        step = 32'd1 << size;
        span = 32'(len + 1) * step;
        case (kind)
            2'b00:   beat_addr = a;
            2'b10: begin
                base = a - (a % span);
                beat_addr = base + (((a - base) + 32'(i) * step) % span);
            end
            default: beat_addr = a + 32'(i) * step;
        endcase
    endfunction

    function automatic string kind_tag(input logic [1:0] kind);
        if (kind == 2'b00) return "R4";
        if (kind == 2'b10) return "R5";
        return "R3";
    endfunction

    // Wishbone slave: random wait, one-cycle acknowledge, logs every cycle.
    always @(negedge clk) begin
        if (rst) begin
            wb_ack   <= 1'b0;
            wb_dat_r <= '0;
            wait_n   = 0;
        end else if (wb_ack) begin
            wb_ack <= 1'b0;
            wait_n = $urandom_range(0, 2);
        end else if (wb_cyc && wb_stb) begin
            if (wait_n == 0) begin
                wb_ack <= 1'b1;
                if (log_n < 2048) begin
                    log_adr[log_n] = wb_adr;
                    log_we[log_n]  = wb_we;
                    log_sel[log_n] = wb_sel;
                    log_n++;
                end
                if (wb_we) begin
                    for (int b = 0; b < 4; b++)
                        if (wb_sel[b]) slv_mem[wb_adr[7:0]][8*b +: 8] = wb_dat_w[8*b +: 8];
                end else begin
                    wb_dat_r <= slv_mem[wb_adr[7:0]];
                end
            end else begin
                wait_n = wait_n - 1;
            end
        end
    end

    // R11: bus idle while a response waits
    always @(negedge clk) begin
        if (!rst && (b_valid || r_valid)) begin
            if (wb_cyc) chk(1'b0, "R11 bus busy during response", {31'd0, wb_cyc}, 32'd0);
        end
    end

    task automatic do_write(input logic [31:0] a, input int len, input int size,
                            input logic [1:0] kind, input logic [7:0] id, input bit full_strb);
        logic [31:0] d [0:255];
        logic [3:0]  s [0:255];
        int start_log;
        int k;
        logic [31:0] ea;
        for (int i = 0; i <= len; i++) begin
            d[i] = $urandom;
            s[i] = full_strb ? 4'hF : 4'($urandom_range(1, 15));
        end
        start_log = log_n;
        fork
            begin
                if (!fast_issue) repeat ($urandom_range(0, 3)) @(negedge clk);
                aw_valid = 1; aw_addr = a; aw_len = 8'(len); aw_size = 3'(size);
                aw_burst = kind; aw_id = id;
                while (!aw_ready) @(negedge clk);
                @(negedge clk);
                aw_valid = 0;
            end
            begin
                for (int i = 0; i <= len; i++) begin
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    w_valid = 1; w_data = d[i]; w_strb = s[i]; w_last = (i == len);
                    while (!w_ready) @(negedge clk);
                    @(negedge clk);
                    w_valid = 0; w_last = 0;
                end
            end
        join
        while (!b_valid) @(negedge clk);
        repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            chk(b_valid == 1'b1, "R9 b_valid dropped before ready", {31'd0, b_valid}, 32'd1);
        end
        chk(b_id == id, "R7 b_id", {24'd0, b_id}, {24'd0, id});
        chk(b_resp == 2'b00, "R7 b_resp", {30'd0, b_resp}, 32'd0);
        b_ready = 1;
        @(negedge clk);
        b_ready = 0;
        chk(b_valid == 1'b0, "R7 one response per burst", {31'd0, b_valid}, 32'd0);
        k = 0;
        for (int j = start_log; j < log_n; j++) begin
            if (log_we[j]) begin
                ea = beat_addr(a, k, len, size, kind);
                if (k <= len) begin
                    chk(log_adr[j] == ea[31:2], kind_tag(kind), {2'b0, log_adr[j]}, {2'b0, ea[31:2]});
                    chk(log_sel[j] == s[k], "R6 write sel", {28'd0, log_sel[j]}, {28'd0, s[k]});
                    for (int b = 0; b < 4; b++)
                        if (s[k][b]) ref_mem[ea[9:2]][8*b +: 8] = d[k][8*b +: 8];
                end
                k++;
            end
        end
        chk(k == len + 1, "R2 write cycle count", 32'(k), 32'(len + 1));
    endtask

    task automatic do_read(input logic [31:0] a, input int len, input int size,
                           input logic [1:0] kind, input logic [7:0] id);
        int start_log;
        int k;
        logic [31:0] ea;
        logic [31:0] held;
        start_log = log_n;
        fork
            begin
                if (!fast_issue) repeat ($urandom_range(0, 3)) @(negedge clk);
                ar_valid = 1; ar_addr = a; ar_len = 8'(len); ar_size = 3'(size);
                ar_burst = kind; ar_id = id;
                while (!ar_ready) @(negedge clk);
                @(negedge clk);
                ar_valid = 0;
            end
            begin
                for (int i = 0; i <= len; i++) begin
                    while (!r_valid) @(negedge clk);
                    ea = beat_addr(a, i, len, size, kind);
                    held = r_data;
                    repeat ($urandom_range(0, 2)) begin
                        @(negedge clk);
                        chk(r_valid && r_data == held, "R9 read beat held", r_data, held);
                    end
                    chk(r_data == ref_mem[ea[9:2]], "R8 r_data", r_data, ref_mem[ea[9:2]]);
                    chk(r_id == id, "R8 r_id", {24'd0, r_id}, {24'd0, id});
                    chk(r_last == (i == len), "R8 r_last", {31'd0, r_last}, {31'd0, (i == len)});
                    chk(r_resp == 2'b00, "R8 r_resp", {30'd0, r_resp}, 32'd0);
                    r_ready = 1;
                    @(negedge clk);
                    r_ready = 0;
                end
            end
        join
        k = 0;
        for (int j = start_log; j < log_n; j++) begin
            if (!log_we[j]) begin
                ea = beat_addr(a, k, len, size, kind);
                if (k <= len) begin
                    chk(log_adr[j] == ea[31:2], kind_tag(kind), {2'b0, log_adr[j]}, {2'b0, ea[31:2]});
                    chk(log_sel[j] == 4'hF, "R6 read sel", {28'd0, log_sel[j]}, 32'hF);
                end
                k++;
            end
        end
        chk(k == len + 1, "R2 read cycle count", 32'(k), 32'(len + 1));
    endtask

    task automatic both_at_once(input bit expect_read_first);
        int s0;
        int flips;
        s0 = log_n;
        fast_issue = 1;
        fork
            do_write(32'h200, 3, 2, 2'b01, 8'h5A, 1'b1);
            do_read(32'h080, 3, 2, 2'b01, 8'hA5);
        join
        fast_issue = 0;
        chk(log_we[s0] == !expect_read_first, "R10 first direction", {31'd0, log_we[s0]},
            {31'd0, !expect_read_first});
        flips = 0;
        for (int j = s0 + 1; j < log_n; j++)
            if (log_we[j] != log_we[j-1]) flips++;
        chk(flips == 1, "R10 bursts not interleaved", 32'(flips), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R2 watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd42));
        for (int i = 0; i < 256; i++) begin
            slv_mem[i] = 32'h3C00_0000 ^ (32'(i) * 32'h0001_0101);
            ref_mem[i] = slv_mem[i];
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(aw_ready && ar_ready, "R1 ready after reset", {30'd0, aw_ready, ar_ready}, 32'd3);
        chk(!b_valid && !r_valid && !wb_cyc, "R1 idle after reset",
            {29'd0, b_valid, r_valid, wb_cyc}, 32'd0);

        // First decision after reset with both pending favours the write.
        both_at_once(1'b0);

        // Directed corners.
        do_write(32'h000, 0, 2, 2'b01, 8'h01, 1'b1);
        do_read(32'h000, 0, 2, 2'b01, 8'h02);
        do_write(32'h108, 3, 2, 2'b10, 8'h03, 1'b1);
        do_read(32'h108, 3, 2, 2'b10, 8'h04);
        do_write(32'h140, 3, 2, 2'b00, 8'h05, 1'b0);
        do_read(32'h140, 2, 2, 2'b00, 8'h06);
        do_write(32'h181, 5, 0, 2'b01, 8'h07, 1'b0);
        do_read(32'h180, 7, 2, 2'b10, 8'h08);
        do_write(32'h000, 255, 2, 2'b01, 8'hFF, 1'b0);
        do_read(32'h3C0, 15, 2, 2'b01, 8'h09);

        // After a write, simultaneous issue goes to the read; after a read, to the write.
        do_write(32'h240, 1, 2, 2'b01, 8'h10, 1'b1);
        both_at_once(1'b1);
        do_read(32'h240, 1, 2, 2'b01, 8'h11);
        both_at_once(1'b0);

        // Constrained random mix.
        for (int n = 0; n < 40; n++) begin
            logic [1:0] kind;
            int size, len;
            logic [31:0] a;
            kind = 2'($urandom_range(0, 2));
            size = $urandom_range(0, 2);
            len  = (kind == 2'b10) ? ((2 << $urandom_range(0, 3)) - 1) : $urandom_range(0, 15);
            a    = 32'($urandom_range(0, 32'h2FF)) & ~((32'd1 << size) - 1);
            if ($urandom_range(0, 1) == 1)
                do_write(a, len, size, kind, 8'($urandom_range(0, 255)), 1'b0);
            else
                do_read(a, len, size, kind, 8'($urandom_range(0, 255)));
        end
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule